// File: doc/BRIEF.md
# GPIO Bank Register File with Per-Bit Write Enables

This block is the register slave of a 32-pin general purpose I/O bank. It holds the pin output values, the pin directions, the interrupt configuration (enable, mask, level/edge type, polarity, any-edge) and the debounce settings. Each of these is driven straight out as a 32-bit vector to the pad and interrupt logic around it. It also returns live status, raw status and pad input words, and a fixed identification word.

Each 32-bit configuration vector is reached through two bus words. The word at the register's base offset carries pins 0 to 15, and the word four bytes above it carries pins 16 to 31. In a write to either word, the upper 16 bits are per-bit write enables for the 16 data bits below them. Software can therefore set or clear any single pin without reading the register first. The bus is a plain strobe port. A write takes effect at the clock edge that samples `wr_en`. Read data appears on `rdata` with `rvalid` one cycle after `rd_en`.

Top module: `gpio_wm_regs`

## Requirements
- R1: After reset, every configuration output, `eoi_pulse`, `deb_div_ctl`, `rdata` and `rvalid` are zero.
- R2: A write to the base word of a masked register changes bit i (i = 0..15) only where `wdata[i+16]` is 1, loading `wdata[i]`. A write to base+4 does the same for bits 16..31, taking data from `wdata[15:0]` and enables from `wdata[31:16]`.
- R3: Reading a masked register's base word returns bits 15:0 in `rdata[15:0]`, and reading base+4 returns bits 31:16 there. `rdata[31:16]` reads zero. `rdata` and `rvalid` are valid in the cycle after `rd_en`.
- R4: The masked registers and their outputs are at these base offsets: 0x00 `pin_out`, 0x08 `pin_oe`, 0x10 `irq_en`, 0x18 `irq_mask`, 0x20 `irq_type`, 0x28 `irq_pol`, 0x30 `irq_any_edge`, 0x38 `deb_en`, 0x40 `deb_div_en`. A 1 in `pin_oe` makes the pin an output, and a 0 makes it an input.
- R5: Offset 0x48 is a plain 32-bit register with no write enables. It is written whole, read back whole and drives `deb_div_ctl`.
- R6: Reads of 0x50, 0x58 and 0x70 return the full 32-bit `stat_in`, `raw_in` and `ext_in`, sampled at the `rd_en` edge.
- R7: A read of 0x78 returns 0x01000C2B.
- R8: A write to 0x60 (pins 0..15) or 0x64 (pins 16..31) pulses `eoi_pulse` for one cycle, on exactly the bits whose data bit and enable bit are both 1. These words read as zero.
- R9: Writes to read-only offsets (0x50, 0x58, 0x70, 0x78) change no output and no read value. Unmapped offsets (for example 0x68, 0x7C) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (8) | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| rvalid | output | 1 | Read data valid |
| stat_in | input | 32 | Masked interrupt status |
| raw_in | input | 32 | Raw interrupt status |
| ext_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin direction, 1 = output |
| irq_en | output | 32 | Interrupt enable |
| irq_mask | output | 32 | Interrupt mask |
| irq_type | output | 32 | Interrupt type, level or edge |
| irq_pol | output | 32 | Interrupt polarity |
| irq_any_edge | output | 32 | Interrupt on either edge |
| deb_en | output | 32 | Debounce enable |
| deb_div_en | output | 32 | Debounce divider enable |
| deb_div_ctl | output | 32 | Debounce divider value |
| eoi_pulse | output | 32 | One-cycle interrupt clear |

## Verification
The bench writes partial enable masks over values that are already set. A design that ignored the enables, or that cleared the unselected bits, would corrupt the neighbouring pins. It writes the upper word with data in the low half, which catches a design that takes data from the wrong half or lands it in the wrong pin range. It also checks that the upper half of a read is zero, which a design returning the raw 32-bit register would fail.

The bench confirms that the divider word is written whole, with no enable masking. It checks that each clear pulse lasts exactly one cycle and covers only the enabled bits. Writes to the status, pad and identification offsets must leave every output and every read value unchanged. Gap offsets must read as zero rather than aliasing a neighbouring register.

// File: rtl/gpio_wm_regs.sv
module gpio_wm_regs #(
  parameter int          AW         = 8,
  parameter logic [31:0] VERSION_ID = 32'h01000C2B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          rvalid,
  input  logic [31:0]   stat_in,
  input  logic [31:0]   raw_in,
  input  logic [31:0]   ext_in,
  output logic [31:0]   pin_out,
  output logic [31:0]   pin_oe,
  output logic [31:0]   irq_en,
  output logic [31:0]   irq_mask,
  output logic [31:0]   irq_type,
  output logic [31:0]   irq_pol,
  output logic [31:0]   irq_any_edge,
  output logic [31:0]   deb_en,
  output logic [31:0]   deb_div_en,
  output logic [31:0]   deb_div_ctl,
  output logic [31:0]   eoi_pulse
);
  localparam int WW = AW - 2;
  localparam int NCFG = 9;
  localparam logic [WW-1:0] W_DIV  = WW'(18);
  localparam logic [WW-1:0] W_STAT = WW'(20);
  localparam logic [WW-1:0] W_RAW  = WW'(22);
  localparam logic [WW-1:0] W_EOI  = WW'(24);
  localparam logic [WW-1:0] W_EXT  = WW'(28);
  localparam logic [WW-1:0] W_VER  = WW'(30);
  localparam logic [WW-1:0] W_GAP  = WW'(31);

  logic [NCFG-1:0][31:0] cfg;
  logic [WW-1:0] widx;
  logic [31:0]   rd_word;

  assign widx = addr[AW-1:2];

  function automatic logic [15:0] merge16(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg         <= '0;
      deb_div_ctl <= '0;
      eoi_pulse   <= '0;
    end else begin
      eoi_pulse <= '0;
      if (wr_en) begin
        for (int k = 0; k < NCFG; k++) begin
          if (widx == WW'(2*k))     cfg[k][15:0]  <= merge16(cfg[k][15:0], wdata);
          if (widx == WW'(2*k + 1)) cfg[k][31:16] <= merge16(cfg[k][31:16], wdata);
        end
        if (widx == W_DIV)        deb_div_ctl       <= wdata;
        if (widx == W_EOI)        eoi_pulse[15:0]   <= wdata[15:0] & wdata[31:16];
        if (widx == W_EOI + 1'b1) eoi_pulse[31:16]  <= wdata[15:0] & wdata[31:16];
      end
    end
  end

  assign pin_out      = cfg[0];
  assign pin_oe       = cfg[1];
  assign irq_en       = cfg[2];
  assign irq_mask     = cfg[3];
  assign irq_type     = cfg[4];
  assign irq_pol      = cfg[5];
  assign irq_any_edge = cfg[6];
  assign deb_en       = cfg[7];
  assign deb_div_en   = cfg[8];

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NCFG; k++) begin
      if (widx == WW'(2*k))     rd_word = {16'h0, cfg[k][15:0]};
      if (widx == WW'(2*k + 1)) rd_word = {16'h0, cfg[k][31:16]};
    end
    case (widx)
      W_DIV:   rd_word = deb_div_ctl;
      W_STAT:  rd_word = stat_in;
      W_RAW:   rd_word = raw_in;
      W_EXT:   rd_word = ext_in;
      W_VER:   rd_word = VERSION_ID;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == '0) |=> ((pin_out[15:0] ^ $past(pin_out[15:0])) & ~$past(wdata[31:16])) == 16'h0);
  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  // R3
  hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && widx < WW'(2*NCFG)) |=> rdata[31:16] == 16'h0);
  // R5
  div_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == W_DIV) |=> deb_div_ctl == $past(wdata));
  // R7
  version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && widx == W_VER) |=> rdata == VERSION_ID);
  // R8
  eoi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> eoi_pulse == 32'h0);
  // R9
  gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && widx == W_GAP) |=> rdata == 32'h0);
  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_out) && $stable(pin_oe) && $stable(deb_div_ctl));
endmodule

// File: tb/gpio_wm_regs_bench.sv
module gpio_wm_regs_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, stat_in = 0, raw_in = 0, ext_in = 0;
  logic [31:0] rdata, pin_out, pin_oe, irq_en, irq_mask, irq_type, irq_pol,
               irq_any_edge, deb_en, deb_div_en, deb_div_ctl, eoi_pulse;
  logic rvalid;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] m [9];
  logic [31:0] exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  gpio_wm_regs u_gpio_wm_regs (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .rvalid,
    .stat_in, .raw_in, .ext_in, .pin_out, .pin_oe, .irq_en, .irq_mask, .irq_type, .irq_pol,
    .irq_any_edge, .deb_en, .deb_div_en, .deb_div_ctl, .eoi_pulse);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] out_of(input int k);
    case (k)
      0: return pin_out;      1: return pin_oe;   2: return irq_en;
      3: return irq_mask;     4: return irq_type; 5: return irq_pol;
      6: return irq_any_edge; 7: return deb_en;   default: return deb_div_en;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic mw(input int k, input bit hi, input logic [15:0] en, input logic [15:0] d);
    wr(8'(8*k + 4*hi), {en, d});
    if (hi) m[k][31:16] = (m[k][31:16] & ~en) | (d & en);
    else    m[k][15:0]  = (m[k][15:0] & ~en) | (d & en);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); exp_q.push_back(exp); tag_q.push_back(req);
    rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rvalid) begin
        if (exp_q.size() == 0) check("read-unexpected", rdata, 32'hx);
        else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic report;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [31:0] snap [10];
    for (int k = 0; k < 9; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 9; k++) check("R1 cfg", out_of(k), 32'h0);
    check("R1 div", deb_div_ctl, 0); check("R1 eoi", eoi_pulse, 0);
    check("R1 rdata", rdata, 0); check("R1 rvalid", {31'h0, rvalid}, 0);

    // R2 masked writes
    mw(0, 0, 16'h00FF, 16'hA5A5); check("R2 low partial", pin_out, m[0]);
    mw(0, 0, 16'h0F00, 16'hFFFF); check("R2 keep others", pin_out, m[0]);
    mw(0, 1, 16'hFFFF, 16'h1234); check("R2 high word", pin_out, m[0]);
    mw(0, 1, 16'h0010, 16'h0000); check("R2 single clear", pin_out, m[0]);
    mw(0, 0, 16'h0000, 16'hFFFF); check("R2 no enable", pin_out, m[0]);
    // R3 readback halves
    rd(8'h00, {16'h0, m[0][15:0]}, "R3 low read");
    rd(8'h04, {16'h0, m[0][31:16]}, "R3 high read");

    // R4 offset map, including direction
    for (int k = 1; k < 9; k++) begin
      mw(k, 0, 16'hFFFF, 16'(k * 16'h1111));
      mw(k, 1, 16'hF0F0, 16'(~(k * 16'h0303)));
      check($sformatf("R4 out %0d", k), out_of(k), m[k]);
      rd(8'(8*k + 4), {16'h0, m[k][31:16]}, "R4 read hi");
    end
    mw(1, 0, 16'h0001, 16'h0001);
    check("R4 pin0 output", {31'h0, pin_oe[0]}, 1);
    mw(1, 0, 16'h0001, 16'h0000);
    check("R4 pin0 input", {31'h0, pin_oe[0]}, 0);

    // R5 plain divider word
    wr(8'h48, 32'hDEADBEEF); check("R5 div port", deb_div_ctl, 32'hDEADBEEF);
    wr(8'h48, 32'h00000001); check("R5 no mask", deb_div_ctl, 32'h00000001);
    rd(8'h48, 32'h00000001, "R5 div read");

    // R6 live read-only inputs
    stat_in = 32'h8000_0001; raw_in = 32'hC3C3_0F0F; ext_in = 32'h1357_9BDF;
    rd(8'h50, 32'h8000_0001, "R6 status");
    rd(8'h58, 32'hC3C3_0F0F, "R6 raw");
    rd(8'h70, 32'h1357_9BDF, "R6 ext");
    ext_in = 32'hFFFF_0000;
    rd(8'h70, 32'hFFFF_0000, "R6 ext updated");
    // R7
    rd(8'h78, 32'h01000C2B, "R7 version");

    // R8 clear pulses
    @(negedge clk); wr_en = 1; addr = 8'h60; wdata = 32'h00FF_0F0F;
    @(negedge clk); wr_en = 0;
    check("R8 low pulse", eoi_pulse, 32'h0000_000F);
    @(negedge clk); check("R8 one cycle", eoi_pulse, 0);
    @(negedge clk); wr_en = 1; addr = 8'h64; wdata = 32'h8001_FFFF;
    @(negedge clk); wr_en = 0;
    check("R8 high pulse", eoi_pulse, 32'h8001_0000);
    @(negedge clk); check("R8 one cycle hi", eoi_pulse, 0);
    rd(8'h60, 0, "R8 read zero");

    // R9 read-only writes ignored, gaps read zero
    for (int k = 0; k < 9; k++) snap[k] = out_of(k);
    snap[9] = deb_div_ctl;
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF); wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF); wr(8'h68, 32'hFFFF_FFFF);
    for (int k = 0; k < 9; k++) check("R9 cfg unchanged", out_of(k), snap[k]);
    check("R9 div unchanged", deb_div_ctl, snap[9]);
    rd(8'h50, 32'h8000_0001, "R9 status kept");
    rd(8'h78, 32'h01000C2B, "R9 version kept");
    rd(8'h7C, 0, "R9 gap 7C");
    rd(8'h68, 0, "R9 gap 68");

    // R1 reset clears again
    mw(0, 0, 16'hFFFF, 16'hFFFF);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    check("R1 after reset", pin_out, 0);

    repeat (3) @(negedge clk);
    check("queue drained", 32'(exp_q.size()), 0);
    report();
  end
endmodule